// File: doc/BRIEF.md
# Single-Word Transforming Copy Engine

This engine is a small accelerator with two faces. A register port lets software program a source address, a destination address and a transform mode, then start the engine. A memory-mapped master port then fetches one 32-bit word from the source address and passes it through the selected transform. The transform is a full bit reversal, a byte-order reversal, a mixed swap, or a plain pass-through. The engine stores the result at the destination address and raises a done flag.

Addresses are taken as absolute locations in the shared system address map, with no offset applied. The master port follows a request/wait-request handshake. A transfer completes only in a cycle where the request is high and wait-request is low. The request stays asserted up to and including that cycle. Read data is taken only in that accepting cycle. Every write stores the whole word, with all four byte enables set.

Top module: `wxdma_top`

## Requirements
- R1: After synchronous reset the engine is idle, `m_read` and `m_write` are low, and every register reads back as zero.
- R2: Register port: word 0 holds the source address, word 1 the destination address, and word 2 the 2-bit mode. Writing word 3 with bit 0 set starts the engine, and writing it with bit 0 clear has no effect. Reading word 3 returns bit 0 = busy and bit 1 = done, with the other bits zero. Words 0 to 2 read back the values written to them.
- R3: After a start the engine raises `m_read` with `m_addr` equal to the source address. It holds both unchanged until the first cycle in which `m_waitreq` is low, and drops `m_read` after that cycle.
- R4: The read word is taken only in the cycle where `m_read` is high and `m_waitreq` is low. Values on `m_rdata` while `m_waitreq` is high have no effect on the stored result.
- R5: After the read the engine raises `m_write` with `m_addr` equal to the destination address and `m_byteen` = 4'b1111. `m_addr` and `m_wdata` stay stable until `m_waitreq` is low, and `m_write` drops after that cycle.
- R6: Mode 0 reverses all 32 bits (bit i goes to bit 31-i); 0xABCDEF12 becomes 0x48F7B3D5.
- R7: Mode 1 reverses the byte order; 0xABCDEF12 becomes 0x12EFCDAB.
- R8: Mode 2 exchanges byte 3 and byte 0 unchanged and bit-reverses bits 23..8 within that field; 0xABCDEF12 becomes 0x12F7B3AB.
- R9: Mode 3 stores the word unchanged.
- R10: The cycle after the write is accepted is a single finishing cycle that is still busy. The engine then returns to idle with done set. Done clears in the cycle a new start is accepted.
- R11: While busy, a start and any write to words 0 to 2 are ignored.
- R12: `m_read` and `m_write` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_addr | input | 2 | Register word select |
| s_write | input | 1 | Register write strobe |
| s_wdata | input | 32 | Register write data |
| s_rdata | output | 32 | Register read data (combinational from s_addr) |
| m_addr | output | ADDR_W | Master address |
| m_read | output | 1 | Master read request |
| m_write | output | 1 | Master write request |
| m_wdata | output | 32 | Master write data |
| m_byteen | output | 4 | Master byte enables |
| m_rdata | input | 32 | Master read data |
| m_waitreq | input | 1 | Master wait-request; a request is accepted when low |

## Verification
A wrong sequencer state shows up at once at the master port as a request that is missing, extra or doubled. It also shows in the busy bit of the status word in the same cycle. A bad captured word, or one sampled while wait-request was high, shows in `m_wdata` on the first cycle of the write phase, one cycle after the read is accepted. The bench drives changing garbage on `m_rdata` during stalls, so an early sample cannot go unnoticed. Register corruption while busy shows on the next register readback and in the address used by the next transfer.

// File: rtl/wxdma_pkg.sv
package wxdma_pkg;

    localparam int WORD_W  = 32;
    localparam int BYTES   = WORD_W / 8;
    localparam int CSR_AW  = 2;
    localparam int MID_LO  = 8;
    localparam int MID_W   = WORD_W - 16;

    typedef enum logic [1:0] {
        XF_BITREV  = 2'd0,
        XF_BYTEREV = 2'd1,
        XF_MIXED   = 2'd2,
        XF_PASS    = 2'd3
    } xform_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_WRITE,
        SQ_DONE
    } seq_e;

    typedef enum logic [CSR_AW-1:0] {
        CSR_SRC  = 2'd0,
        CSR_DST  = 2'd1,
        CSR_MODE = 2'd2,
        CSR_CTRL = 2'd3
    } csr_e;

    typedef struct packed {
        logic done;
        logic busy;
    } status_t;

    function automatic logic [MID_W-1:0] mid_flip(input logic [MID_W-1:0] v);
        logic [MID_W-1:0] r;
        for (int k = 0; k < MID_W; k++) r[k] = v[MID_W-1-k];
        return r;
    endfunction

endpackage

// File: rtl/wxdma_xform.sv
module wxdma_xform
    import wxdma_pkg::*;
(
    input  xform_e             mode,
    input  logic [WORD_W-1:0]  din,
    output logic [WORD_W-1:0]  dout
);
    logic [WORD_W-1:0] bit_rev;
    logic [WORD_W-1:0] byte_rev;
    logic [WORD_W-1:0] mixed;

    for (genvar i = 0; i < WORD_W; i++) begin : g_bits
        assign bit_rev[i] = din[WORD_W-1-i];
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_bytes
        assign byte_rev[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
    end

    assign mixed = {din[7:0], mid_flip(din[MID_LO +: MID_W]), din[WORD_W-1 -: 8]};

    always_comb begin
        unique case (mode)
            XF_BITREV:  dout = bit_rev;
            XF_BYTEREV: dout = byte_rev;
            XF_MIXED:   dout = mixed;
            default:    dout = din;
        endcase
    end
endmodule

// File: rtl/wxdma_regs.sv
module wxdma_regs
    import wxdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CSR_AW-1:0] s_addr,
    input  logic              s_write,
    input  logic [WORD_W-1:0] s_wdata,
    output logic [WORD_W-1:0] s_rdata,
    input  logic              busy,
    input  logic              fin,
    output logic              start,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst,
    output xform_e            mode,
    output logic              done
);
    logic [ADDR_W-1:0] src_q, dst_q;
    xform_e            mode_q;
    logic              done_q;
    status_t           stat;
    logic              cfg_we;

    assign cfg_we = s_write && !busy;
    assign start  = cfg_we && (csr_e'(s_addr) == CSR_CTRL) && s_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            mode_q <= XF_BITREV;
            done_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                unique case (csr_e'(s_addr))
                    CSR_SRC:  src_q  <= s_wdata[ADDR_W-1:0];
                    CSR_DST:  dst_q  <= s_wdata[ADDR_W-1:0];
                    CSR_MODE: mode_q <= xform_e'(s_wdata[1:0]);
                    default:  ;
                endcase
            end
            if (start)    done_q <= 1'b0;
            else if (fin) done_q <= 1'b1;
        end
    end

    assign stat = '{done: done_q, busy: busy};

    always_comb begin
        unique case (csr_e'(s_addr))
            CSR_SRC:  s_rdata = WORD_W'(src_q);
            CSR_DST:  s_rdata = WORD_W'(dst_q);
            CSR_MODE: s_rdata = WORD_W'(mode_q);
            default:  s_rdata = WORD_W'(stat);
        endcase
    end

    assign src  = src_q;
    assign dst  = dst_q;
    assign mode = mode_q;
    assign done = done_q;

    assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && s_write) |=> ($stable(src_q) && $stable(dst_q) && $stable(mode_q)));
endmodule

// File: rtl/wxdma_seq.sv
module wxdma_seq
    import wxdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [WORD_W-1:0] xf_word,
    input  logic              m_waitreq,
    output logic              m_read,
    output logic              m_write,
    output logic [ADDR_W-1:0] m_addr,
    output logic [WORD_W-1:0] m_wdata,
    output logic              busy,
    output logic              fin
);
    seq_e              state_q;
    logic [WORD_W-1:0] wd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            wd_q    <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE:  if (start) state_q <= SQ_READ;
                SQ_READ:  if (!m_waitreq) begin
                              wd_q    <= xf_word;
                              state_q <= SQ_WRITE;
                          end
                SQ_WRITE: if (!m_waitreq) state_q <= SQ_DONE;
                default:  state_q <= SQ_IDLE;
            endcase
        end
    end

    assign m_read  = (state_q == SQ_READ);
    assign m_write = (state_q == SQ_WRITE);
    assign m_addr  = m_read ? src : (m_write ? dst : '0);
    assign m_wdata = wd_q;
    assign busy    = (state_q != SQ_IDLE);
    assign fin     = (state_q == SQ_DONE);

    assert_read_held_R3: assert property (@(posedge clk) disable iff (rst)
        (m_read && m_waitreq) |=> (m_read && $stable(m_addr)));

    assert_write_held_R5: assert property (@(posedge clk) disable iff (rst)
        (m_write && m_waitreq) |=> (m_write && $stable(m_addr) && $stable(m_wdata)));

    assert_one_request_R12: assert property (@(posedge clk) disable iff (rst)
        !(m_read && m_write));
endmodule

// File: rtl/wxdma_top.sv
module wxdma_top
    import wxdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        s_addr,
    input  logic              s_write,
    input  logic [31:0]       s_wdata,
    output logic [31:0]       s_rdata,
    output logic [ADDR_W-1:0] m_addr,
    output logic              m_read,
    output logic              m_write,
    output logic [31:0]       m_wdata,
    output logic [3:0]        m_byteen,
    input  logic [31:0]       m_rdata,
    input  logic              m_waitreq
);
    logic              start, busy, fin, done;
    logic [ADDR_W-1:0] src, dst;
    xform_e            mode;
    logic [WORD_W-1:0] xf_word;

    wxdma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .s_addr(s_addr), .s_write(s_write),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .busy(busy), .fin(fin),
        .start(start), .src(src), .dst(dst), .mode(mode), .done(done)
    );

    wxdma_xform u_xform (.mode(mode), .din(m_rdata), .dout(xf_word));

    wxdma_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst(rst), .start(start), .src(src), .dst(dst),
        .xf_word(xf_word), .m_waitreq(m_waitreq), .m_read(m_read),
        .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .busy(busy), .fin(fin)
    );

    assign m_byteen = {BYTES{1'b1}};

    assert_done_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (m_write && !m_waitreq) |=> ##1 (done && !m_read && !m_write));

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (start) |=> (!done && m_read));
endmodule

// File: tb/wxdma_top_tb.sv
module wxdma_top_tb;
    localparam int ADDR_W = 32;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst;
    logic [1:0]        s_addr;
    logic              s_write;
    logic [31:0]       s_wdata, s_rdata;
    logic [ADDR_W-1:0] m_addr;
    logic              m_read, m_write;
    logic [31:0]       m_wdata, m_rdata;
    logic [3:0]        m_byteen;
    logic              m_waitreq;

    logic [31:0] mem [0:255];
    logic [31:0] junk;

    assign m_rdata = m_waitreq ? junk : mem[m_addr[9:2]];

    wxdma_top #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .s_addr(s_addr), .s_write(s_write),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .m_addr(m_addr),
        .m_read(m_read), .m_write(m_write), .m_wdata(m_wdata),
        .m_byteen(m_byteen), .m_rdata(m_rdata), .m_waitreq(m_waitreq)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // behavioural reference: 0 idle, 1 fetching, 2 storing, 3 finishing
    int          ms;
    logic [31:0] msrc, mdst, mwd;
    logic [1:0]  mmode;
    logic        mdone;
    int          wait_n, wcnt;

    function automatic logic [31:0] ref_xf(input logic [31:0] w, input logic [1:0] md);
        logic [31:0] r;
        r = w;
        case (md)
            2'd0: for (int i = 0; i < 32; i++) r[i] = w[31-i];
            2'd1: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
            2'd2: begin
                r[31:24] = w[7:0];
                r[7:0]   = w[31:24];
                for (int i = 0; i < 16; i++) r[8+i] = w[23-i];
            end
            default: r = w;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [31:0] e;
        check(m_read === (ms == 1), "R3", 32'(m_read), 32'(ms == 1));
        check(m_write === (ms == 2), "R5", 32'(m_write), 32'(ms == 2));
        check(!(m_read && m_write), "R12", {m_read, m_write}, 0);
        if (ms == 1) check(m_addr === msrc, "R3", m_addr, msrc);
        if (ms == 2) begin
            check(m_addr === mdst, "R5", m_addr, mdst);
            check(m_wdata === mwd, "R4", m_wdata, mwd);
            check(m_byteen === 4'hF, "R5", 32'(m_byteen), 32'hF);
        end
        case (s_addr)
            2'd0:    e = msrc;
            2'd1:    e = mdst;
            2'd2:    e = {30'b0, mmode};
            default: e = {30'b0, mdone, ms != 0};
        endcase
        check(s_rdata === e, "R2", s_rdata, e);
    endtask

    task automatic cyc();
        logic req;
        int   nms;
        req = m_read || m_write;
        m_waitreq = req && (wcnt != 0);
        nms = ms;
        if (s_write && ms == 0) begin
            case (s_addr)
                2'd0: msrc  = s_wdata;
                2'd1: mdst  = s_wdata;
                2'd2: mmode = s_wdata[1:0];
                default: if (s_wdata[0]) begin nms = 1; mdone = 1'b0; end
            endcase
        end
        case (ms)
            1: if (!m_waitreq) begin mwd = ref_xf(mem[msrc[9:2]], mmode); nms = 2; end
            2: if (!m_waitreq) nms = 3;
            3: begin nms = 0; mdone = 1'b1; end
            default: ;
        endcase
        if (req) begin
            if (m_waitreq) wcnt--;
            else wcnt = wait_n;
        end
        if (m_write && !m_waitreq) mem[m_addr[9:2]] = m_wdata;
        ms = nms;
        @(posedge clk);
        @(negedge clk);
        junk = {junk[30:0], junk[31] ^ junk[21] ^ junk[1] ^ junk[0]};
        compare();
        s_write = 1'b0;
    endtask

    task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
        s_addr = a; s_write = 1'b1; s_wdata = d;
        cyc();
        s_addr = 2'd3;
    endtask

    task automatic finish_op();
        for (int i = 0; i < 60 && !(ms == 0 && mdone); i++) cyc();
        cyc();
    endtask

    task automatic run_op(input logic [31:0] sa, input logic [31:0] da, input logic [1:0] md,
                          input logic [31:0] data, input int wt, input logic [31:0] exp, input string tag);
        mem[sa[9:2]] = data;
        wait_n = wt; wcnt = wt;
        csr_wr(2'd0, sa);
        csr_wr(2'd1, da);
        csr_wr(2'd2, {30'b0, md});
        csr_wr(2'd3, 32'h1);
        check(s_rdata[1:0] === 2'b01, "R10 start clears done", 32'(s_rdata[1:0]), 32'h1);
        finish_op();
        check(mem[da[9:2]] === exp, tag, mem[da[9:2]], exp);
        check(s_rdata[1:0] === 2'b10, "R10 done after finish", 32'(s_rdata[1:0]), 32'h2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h5A5A0000 + 32'(i);
        junk = 32'hC3A5_9E17;
        rst = 1'b1; s_addr = 2'd3; s_write = 1'b0; s_wdata = '0; m_waitreq = 1'b0;
        ms = 0; msrc = '0; mdst = '0; mwd = '0; mmode = '0; mdone = 1'b0;
        wait_n = 0; wcnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(!m_read && !m_write, "R1", {m_read, m_write}, 0);
        for (int a = 0; a < 4; a++) begin
            s_addr = 2'(a);
            #1;
            check(s_rdata === 32'h0, "R1", s_rdata, 0);
        end
        s_addr = 2'd3;

        run_op(32'h100, 32'h200, 2'd0, 32'hABCDEF12, 0, 32'h48F7B3D5, "R6");
        run_op(32'h104, 32'h204, 2'd1, 32'hABCDEF12, 2, 32'h12EFCDAB, "R7");
        run_op(32'h108, 32'h208, 2'd2, 32'hABCDEF12, 3, 32'h12F7B3AB, "R8");
        run_op(32'h10C, 32'h20C, 2'd3, 32'h0400F0F4, 1, 32'h0400F0F4, "R9");
        // R4: long stalls with garbage on read data
        run_op(32'h110, 32'h210, 2'd0, 32'h0400F0F4, 5, 32'h2F0F0020, "R4");

        // R2: start bit clear does nothing
        csr_wr(2'd3, 32'h2);
        cyc();
        check(s_rdata[0] === 1'b0 && !m_read, "R2 no start", 32'(s_rdata[0]), 0);

        // R11: writes while busy are ignored
        mem[32'h114 >> 2] = 32'h11223344;
        wait_n = 4; wcnt = 4;
        csr_wr(2'd0, 32'h114);
        csr_wr(2'd1, 32'h214);
        csr_wr(2'd2, 32'h1);
        csr_wr(2'd3, 32'h1);
        csr_wr(2'd0, 32'h120);
        csr_wr(2'd1, 32'h220);
        csr_wr(2'd2, 32'h0);
        csr_wr(2'd3, 32'h1);
        finish_op();
        check(mem[32'h214 >> 2] === 32'h44332211, "R11 result", mem[32'h214 >> 2], 32'h44332211);
        check(mem[32'h220 >> 2] === 32'h5A5A0088, "R11 no stray write", mem[32'h220 >> 2], 32'h5A5A0088);
        s_addr = 2'd0; #1;
        check(s_rdata === 32'h114, "R11 src kept", s_rdata, 32'h114);
        s_addr = 2'd2; #1;
        check(s_rdata === 32'h1, "R11 mode kept", s_rdata, 32'h1);
        s_addr = 2'd3;
        cyc();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule